// File: doc/BRIEF.md
# Consecutive-Ones Pair Suppressor

This block filters a serial bit stream. One bit comes in on each clock in which the valid strobe is high, and for each of those bits exactly one bit goes out. Zeros pass through unchanged. Within a run of ones, the block keeps the first one and clears the one after it. In a longer run it keeps and clears in turn, so `11` becomes `10`, `111` becomes `101` and `1111` becomes `1010`. A zero ends the run and rearms the block. It behaves like a divide-by-two scaler that restarts after every zero.

Only one bit of history is kept. It records whether the last one was passed. The output is registered, so the result for an input bit appears one clock after that bit is sampled. In a cycle without a valid bit, the output next cycle is zero and the history is held. A run can therefore span idle gaps.

Top module: `ones_pair_suppress`

## Requirements
- R1: After reset, whether asserted at start-up or in the middle of a run, `bit_o` is 0 and the next valid one is passed as 1.
- R2: A valid input 0 produces output 0 and rearms the block, so the next valid one is passed.
- R3: A valid input 1 that is the first one after reset or after a valid zero produces output 1.
- R4: A valid input 1 that directly follows a passed one, counting only valid bits, produces output 0.
- R5: Within a run of valid ones, the outputs alternate 1,0,1,0,… starting with 1. For example, 111 gives 101 and 1111 gives 1010.
- R6: The output bit for an input sampled at clock edge k appears on `bit_o` just after edge k and holds until edge k+1.
- R7: A cycle with `valid_i` low gives output 0 after the next edge and leaves the history unchanged. For example, valid 1, idle, valid 1 gives 1, 0, 0.
- R8: The valid sequence 00110110 produces 00100100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | High when `bit_i` carries a stream bit |
| bit_i | input | 1 | Input stream bit |
| bit_o | output | 1 | Filtered stream bit, registered |

## Verification
Each result is due one clock after its input is sampled: the history register and the output register both update on the same edge as the input. The bench drives inputs on the falling edge and checks `bit_o` shortly after the next rising edge. In the latency test it also checks `bit_o` before that edge, to show the new value has not yet appeared. Idle cycles are checked the same way: zero one edge later. A valid one sent after the idle cycles confirms that the history was held across them.

// File: rtl/ones_pair_pkg.sv
package ones_pair_pkg;

  // ST_ARMED: next one is passed; ST_MUTED: last one was passed
  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_MUTED = 1'b1
  } pair_state_e;

  function automatic pair_state_e pair_next(pair_state_e s, logic v, logic d);
    pair_state_e n;
    if (!v)            n = s;
    else if (!d)       n = ST_ARMED;
    else if (s == ST_ARMED) n = ST_MUTED;
    else               n = ST_ARMED;
    return n;
  endfunction

  function automatic logic pair_emit(pair_state_e s, logic v, logic d);
    return v & d & (s == ST_ARMED);
  endfunction

endpackage

// File: rtl/ones_pair_state.sv
module ones_pair_state
  import ones_pair_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        bit_i,
  output pair_state_e state_o
);

  pair_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARMED;
    else         state_q <= pair_next(state_q, valid_i, bit_i);
  end

  assign state_o = state_q;

  a_r2_zero_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bit_i) |=> (state_q == ST_ARMED));

  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));

  a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bit_i) |=> (state_q != $past(state_q)));

endmodule

// File: rtl/ones_pair_emit.sv
module ones_pair_emit
  import ones_pair_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        bit_i,
  input  pair_state_e state_i,
  output logic        bit_o
);

  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b0;
    else         bit_q <= pair_emit(state_i, valid_i, bit_i);
  end

  assign bit_o = bit_q;

  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !bit_q);

  a_r2_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bit_i) |=> !bit_q);

endmodule

// File: rtl/ones_pair_suppress.sv
module ones_pair_suppress
  import ones_pair_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic bit_o
);

  pair_state_e state;

  ones_pair_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .bit_i   (bit_i),
    .state_o (state)
  );

  ones_pair_emit u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .bit_i   (bit_i),
    .state_i (state),
    .bit_o   (bit_o)
  );

  // R3/R6: armed one shows up as 1 one edge later
  a_r3_pass_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bit_i && state == ST_ARMED) |=> bit_o);

  // R4: one after a passed one is cleared
  a_r4_suppress_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bit_i && state == ST_MUTED) |=> !bit_o);

  // R4: a passed one always leaves the block muted
  a_r4_muted_after_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> (state == ST_MUTED));

endmodule

// File: tb/ones_pair_suppress_bench.sv
`timescale 1ns/1ps
module ones_pair_suppress_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic din = 1'b0;
  logic dout;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ones_pair_suppress u_ones_pair_suppress (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .bit_i (din), .bit_o (dout)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: bit_o=%b expected %b at %0t", req, dout, exp, $time);
    end
  endtask

  // drive at falling edge, sample 1 ns after rising edge
  task automatic step(input logic v, input logic d, input logic exp, input string req);
    @(negedge clk);
    valid = v; din = d;
    @(posedge clk);
    #1;
    check(exp, req);
  endtask

  task automatic stream(input logic [15:0] ins, input logic [15:0] exps,
                        input int len, input string req);
    for (int i = len - 1; i >= 0; i--) step(1'b1, ins[i], exps[i], req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 check(1'b0, "R1 reset output");
    @(negedge clk) rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, "R1 first one after reset");
    step(1'b1, 1'b0, 1'b0, "R2 zero");
  endtask

  task automatic t_example;
    stream(16'b00110110, 16'b00100100, 8, "R8 example");
  endtask

  task automatic t_runs;
    step(1'b1, 1'b0, 1'b0, "R2 rearm");
    stream(16'b1110, 16'b1010, 4, "R5 run of three");
    stream(16'b11110, 16'b10100, 5, "R5 run of four");
    stream(16'b1111111, 16'b1010101, 7, "R5 run of seven");
    step(1'b1, 1'b0, 1'b0, "R2 end run");
    step(1'b1, 1'b1, 1'b1, "R3 pass after zero");
    step(1'b1, 1'b1, 1'b0, "R4 second suppressed");
    step(1'b1, 1'b0, 1'b0, "R2 zero passes");
  endtask

  task automatic t_idle;
    step(1'b1, 1'b1, 1'b1, "R3 before gap");
    step(1'b0, 1'b1, 1'b0, "R7 idle output low");
    step(1'b0, 1'b0, 1'b0, "R7 idle output low");
    step(1'b1, 1'b1, 1'b0, "R7 history held across gap");
    step(1'b0, 1'b1, 1'b0, "R7 idle output low");
    step(1'b1, 1'b1, 1'b1, "R7 held armed across gap");
    step(1'b1, 1'b0, 1'b0, "R2 zero");
  endtask

  task automatic t_latency;
    @(negedge clk);
    valid = 1'b1; din = 1'b1;
    #1 check(1'b0, "R6 not before edge");
    @(posedge clk);
    #1 check(1'b1, "R6 one edge later");
    @(negedge clk);
    valid = 1'b0; din = 1'b0;
    #1 check(1'b1, "R6 held until next edge");
    @(posedge clk);
    #1 check(1'b0, "R6 cleared next edge");
  endtask

  task automatic t_mid_reset;
    step(1'b1, 1'b0, 1'b0, "R2 zero");
    step(1'b1, 1'b1, 1'b1, "R3 pass");
    @(negedge clk);
    valid = 1'b0; rst_n = 1'b0;
    #1 check(1'b0, "R1 async reset clears output");
    @(negedge clk) rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, "R1 rearmed by reset");
  endtask

  initial begin
    t_reset();
    t_example();
    t_runs();
    t_idle();
    t_latency();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: bench hung, actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule